// File: doc/BRIEF.md
# Command and Result Phase Handshake Sequencer

This block sits behind the single byte-wide data port of a disk-controller style command interface. It tracks each command through three phases. In the command phase the host writes an opcode and its parameter bytes. In the execution phase the block waits for an external completion strobe. In the result phase the host reads back result bytes. Throughout, it publishes a status byte that tells the host whether the port may be touched, in which direction, and whether a command is in progress.

Each opcode has a fixed shape, taken from a small built-in table: how many parameter bytes it takes, whether it has an execution phase, and how many result bytes it returns. An opcode that is not in the table goes straight to a single-byte result phase that reports an invalid command. After every byte the port accepts, the ready flag drops for a programmable number of clock cycles. This enforces a minimum spacing between host transfers.

Top module: `fifo_phase_seq`

## Requirements
- R1: After reset the status byte reads 0x80 and `rd_data` reads 0x00.
- R2: The status byte carries ready in bit 7, read-direction in bit 6, execution-in-progress in bit 5 and command-busy in bit 4. Bits 3..0 read 0. In the idle command phase it reads 0x80.
- R3: Once an opcode that expects parameters has been accepted, the status shows busy set and direction clear (0x90 when ready) until its last parameter has been accepted.
- R4: After every accepted byte, the ready bit stays low for exactly GAP_CYC clock cycles. A write or read offered while ready is low is ignored and does not count as a byte.
- R5: During execution the status reads 0x30 and writes are ignored. A pulse on `exec_done` in that phase moves the block to the result phase on the next cycle (0xD0). `exec_done` in any other phase has no effect.
- R6: While result bytes remain, the status reads 0xD0, so (status & 0x50) == 0x50. Result byte k (k counted from 0) of a known opcode is {k[3:0], opcode[3:0]}.
- R7: After the last result byte has been read, the status returns to 0x80 once the gap expires: busy and direction are clear.
- R8: A read while ready is low, or while not in the result phase, returns 0x00 and does not advance to the next result byte.
- R9: An opcode missing from the table enters a one-byte result phase that returns 0x80 and then returns to idle.
- R10: The opcode table holds 0x03 (2 parameters, no execution, no results), 0x07 (1 parameter, execution, 2 results), 0x08 (no parameters, no execution, 2 results) and 0x06 (8 parameters, execution, 7 results).
- R11: A command with no result bytes drops busy straight after its last parameter (or after `exec_done`), giving status 0x80 once the gap expires.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host offers a byte on `wr_data` this cycle |
| wr_data | input | 8 | Command or parameter byte from the host |
| rd_en | input | 1 | Host reads the port this cycle |
| rd_data | output | 8 | Result byte when a read is accepted, else 0x00 |
| exec_done | input | 1 | Completion strobe for the stubbed execution phase |
| status | output | 8 | Status byte: ready, direction, executing, busy |

## Verification
The bench builds the block with GAP_CYC set to 6. At that value the full ready-low window after each byte can be counted cycle by cycle. The window is also long enough for the bench to offer a stray write or read inside it and then show that the write was discarded and the result pointer held. A small gap also lets the longest table entry, with eight parameters and seven results, finish in a few hundred cycles. All four table shapes and the invalid-opcode path are reached at this setting.

// File: rtl/fps_pkg.sv
package fps_pkg;

   localparam int CNT_W = 4;

   localparam int ST_RQM  = 7;
   localparam int ST_DIO  = 6;
   localparam int ST_NDMA = 5;
   localparam int ST_BSY  = 4;

   localparam logic [7:0] INVALID_CODE = 8'h80;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_CMD,
      PH_EXEC,
      PH_RES
   } phase_t;

   typedef struct packed {
      logic             known;
      logic [CNT_W-1:0] n_param;
      logic             has_exec;
      logic [CNT_W-1:0] n_result;
   } shape_t;

   function automatic shape_t decode_op(input logic [7:0] op);
      shape_t s;
      s = '0;
      case (op)
         8'h03: begin s.known = 1'b1; s.n_param = 4'd2; s.has_exec = 1'b0; s.n_result = 4'd0; end
         8'h07: begin s.known = 1'b1; s.n_param = 4'd1; s.has_exec = 1'b1; s.n_result = 4'd2; end
         8'h08: begin s.known = 1'b1; s.n_param = 4'd0; s.has_exec = 1'b0; s.n_result = 4'd2; end
         8'h06: begin s.known = 1'b1; s.n_param = 4'd8; s.has_exec = 1'b1; s.n_result = 4'd7; end
         default: s = '0;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/fps_gap_timer.sv
module fps_gap_timer #(
   parameter int GAP_CYC = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic active
);
   localparam int W = (GAP_CYC < 2) ? 1 : $clog2(GAP_CYC + 1);

   generate
      if (GAP_CYC < 1) begin : g_bad
         $error("fps_gap_timer: GAP_CYC must be at least 1");
      end else if (GAP_CYC == 1) begin : g_single
         logic hold_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hold_q <= 1'b0;
            else        hold_q <= start;
         end
         assign active = hold_q;
      end else begin : g_count
         logic [W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           cnt_q <= '0;
            else if (start)       cnt_q <= W'(GAP_CYC);
            else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
         end
         assign active = (cnt_q != '0);

         AST_GAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
            start |=> active) else $error("gap not started"); // R4
      end
   endgenerate

endmodule

// File: rtl/fps_byte_cnt.sv
module fps_byte_cnt #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic [W-1:0] left,
   output logic [W-1:0] idx,
   output logic         last
);
   generate
      if (W < 2) begin : g_bad
         $error("fps_byte_cnt: W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left <= '0;
         idx  <= '0;
      end else if (load) begin
         left <= load_val;
         idx  <= '0;
      end else if (dec) begin
         left <= left - 1'b1;
         idx  <= idx + 1'b1;
      end
   end

   assign last = (left == W'(1));

   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      dec |-> (left != '0)) else $error("counter underflow"); // R10

endmodule

// File: rtl/fifo_phase_seq.sv
module fifo_phase_seq #(
   parameter int GAP_CYC = 100
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] wr_data,
   input  logic       rd_en,
   output logic [7:0] rd_data,
   input  logic       exec_done,
   output logic [7:0] status
);
   import fps_pkg::*;

   localparam int W = CNT_W;

   generate
      if (GAP_CYC < 1) begin : g_bad_gap
         $error("fifo_phase_seq: GAP_CYC must be at least 1");
      end
   endgenerate

   phase_t     phase_q, phase_d;
   shape_t     shape_q, shape_new;
   logic [3:0] op_q;
   logic       unk_q;

   logic         gap_active;
   logic         rqm, dio, ndma, bsy;
   logic         wr_acc, rd_acc;
   logic         ld;
   logic [W-1:0] ld_val;
   logic         dec;
   logic [W-1:0] left, idx;
   logic         last;
   logic [7:0]   res_byte;

   assign rqm  = !gap_active && (phase_q != PH_EXEC);
   assign dio  = (phase_q == PH_RES);
   assign ndma = (phase_q == PH_EXEC);
   assign bsy  = (phase_q != PH_IDLE);

   always_comb begin
      status          = '0;
      status[ST_RQM]  = rqm;
      status[ST_DIO]  = dio;
      status[ST_NDMA] = ndma;
      status[ST_BSY]  = bsy;
   end

   assign wr_acc    = wr_en && rqm && !dio;
   assign rd_acc    = rd_en && rqm && dio;
   assign shape_new = decode_op(wr_data);

   always_comb begin
      phase_d = phase_q;
      ld      = 1'b0;
      ld_val  = '0;
      dec     = 1'b0;
      case (phase_q)
         PH_IDLE: if (wr_acc) begin
            if (!shape_new.known) begin
               phase_d = PH_RES; ld = 1'b1; ld_val = W'(1);
            end else if (shape_new.n_param != '0) begin
               phase_d = PH_CMD; ld = 1'b1; ld_val = shape_new.n_param;
            end else if (shape_new.has_exec) begin
               phase_d = PH_EXEC;
            end else if (shape_new.n_result != '0) begin
               phase_d = PH_RES; ld = 1'b1; ld_val = shape_new.n_result;
            end
         end
         PH_CMD: if (wr_acc) begin
            if (last) begin
               if (shape_q.has_exec) begin
                  phase_d = PH_EXEC;
               end else if (shape_q.n_result != '0) begin
                  phase_d = PH_RES; ld = 1'b1; ld_val = shape_q.n_result;
               end else begin
                  phase_d = PH_IDLE;
               end
            end else begin
               dec = 1'b1;
            end
         end
         PH_EXEC: if (exec_done) begin
            if (shape_q.n_result != '0) begin
               phase_d = PH_RES; ld = 1'b1; ld_val = shape_q.n_result;
            end else begin
               phase_d = PH_IDLE;
            end
         end
         PH_RES: if (rd_acc) begin
            if (last) phase_d = PH_IDLE;
            else      dec = 1'b1;
         end
         default: phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         shape_q <= '0;
         op_q    <= '0;
         unk_q   <= 1'b0;
      end else begin
         phase_q <= phase_d;
         if (phase_q == PH_IDLE && wr_acc) begin
            shape_q <= shape_new;
            op_q    <= wr_data[3:0];
            unk_q   <= !shape_new.known;
         end
      end
   end

   fps_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (wr_acc || rd_acc),
      .active (gap_active)
   );

   fps_byte_cnt #(.W(W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld),
      .load_val (ld_val),
      .dec      (dec),
      .left     (left),
      .idx      (idx),
      .last     (last)
   );

   assign res_byte = unk_q ? INVALID_CODE : {idx[3:0], op_q};
   assign rd_data  = rd_acc ? res_byte : 8'h00;

   AST_WR_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && status[7] && !status[6]) |=> !status[7]) else $error("no gap after write"); // R4
   AST_RES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      status[6] |-> status[4]) else $error("result phase without busy"); // R6
   AST_EXEC_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      status[5] |-> (!status[7] && !status[6])) else $error("ready during execution"); // R5
   AST_NDMA_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(status[5]) |-> (status[6] || !status[4])) else $error("bad exit from execution"); // R5
   AST_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !(status[7] && status[6])) |-> (rd_data == 8'h00)) else $error("data without ready"); // R8
   AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (status[6] && !status[7]) |=> $stable(idx)) else $error("pointer moved while not ready"); // R8

endmodule

// File: tb/fifo_phase_seq_tb.sv
module fifo_phase_seq_tb;
   localparam int GAP = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       rd_en = 1'b0;
   logic [7:0] rd_data;
   logic       exec_done = 1'b0;
   logic [7:0] status;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   fifo_phase_seq #(.GAP_CYC(GAP)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data), .exec_done(exec_done), .status(status)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wait_ready(input logic dir);
      for (int i = 0; i < 1000; i++) begin
         if (status[7] && status[6] == dir) return;
         @(negedge clk);
      end
      check("ready timeout", 0, 1);
   endtask

   task automatic put_byte(input logic [7:0] b);
      wait_ready(1'b0);
      wr_en = 1'b1; wr_data = b;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic get_byte(output logic [7:0] b);
      wait_ready(1'b1);
      rd_en = 1'b1;
      #1 b = rd_data;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 status", status, 8'h80);
      check("R1 rd_data", rd_data, 8'h00);
      rd_en = 1'b1;
      #1 check("R8 read in idle", rd_data, 8'h00);
      @(negedge clk); rd_en = 1'b0;
      check("R2 idle status", status, 8'h80);
      exec_done = 1'b1; @(negedge clk); exec_done = 1'b0;
      check("R5 exec_done in idle", status, 8'h80);
   endtask

   task automatic t_no_result_cmd();
      int n;
      put_byte(8'h03);
      check("R4 low after opcode", status, 8'h10);
      n = 0;
      while (!status[7] && n < 100) begin n++; @(negedge clk); end
      check("R4 gap length", n, GAP);
      check("R3 param phase", status, 8'h90);
      put_byte(8'h11);
      wr_en = 1'b1; wr_data = 8'h22;
      @(negedge clk); wr_en = 1'b0;
      wait_ready(1'b0);
      check("R4 write in gap ignored", status, 8'h90);
      put_byte(8'h33);
      wait_ready(1'b0);
      check("R11 back to idle", status, 8'h80);
   endtask

   task automatic t_result_only();
      logic [7:0] b;
      put_byte(8'h08);
      wait_ready(1'b1);
      check("R6 result status", status, 8'hD0);
      check("R6 mask 0x50", status & 8'h50, 8'h50);
      get_byte(b);
      check("R6 byte0", b, 8'h08);
      rd_en = 1'b1;
      #1 check("R8 read in gap", rd_data, 8'h00);
      @(negedge clk); rd_en = 1'b0;
      get_byte(b);
      check("R8 pointer held", b, 8'h18);
      wait_ready(1'b0);
      check("R7 back to idle", status, 8'h80);
   endtask

   task automatic t_exec_cmd();
      logic [7:0] b;
      put_byte(8'h07);
      check("R3 busy after opcode", status & 8'h50, 8'h10);
      put_byte(8'h00);
      check("R5 exec status", status, 8'h30);
      repeat (GAP + 3) @(negedge clk);
      wr_en = 1'b1; wr_data = 8'h55;
      @(negedge clk); wr_en = 1'b0;
      check("R5 exec held", status, 8'h30);
      exec_done = 1'b1; @(negedge clk); exec_done = 1'b0;
      check("R5 to result", status, 8'hD0);
      get_byte(b); check("R10 0x07 byte0", b, 8'h07);
      get_byte(b); check("R10 0x07 byte1", b, 8'h17);
      wait_ready(1'b0);
      check("R7 idle after 0x07", status, 8'h80);
   endtask

   task automatic t_unknown();
      logic [7:0] b;
      put_byte(8'h1F);
      wait_ready(1'b1);
      check("R9 result status", status, 8'hD0);
      get_byte(b);
      check("R9 invalid code", b, 8'h80);
      wait_ready(1'b0);
      check("R9 idle after invalid", status, 8'h80);
   endtask

   task automatic t_long_cmd();
      logic [7:0] b;
      put_byte(8'h06);
      for (int i = 0; i < 7; i++) begin
         put_byte(8'(i));
         check("R10 still in params", status & 8'h70, 8'h10);
      end
      put_byte(8'hAA);
      check("R10 exec after 8 params", status, 8'h30);
      exec_done = 1'b1; @(negedge clk); exec_done = 1'b0;
      for (int k = 0; k < 7; k++) begin
         get_byte(b);
         check("R10 0x06 result", b, (k << 4) | 8'h06);
      end
      wait_ready(1'b0);
      check("R7 idle after 0x06", status, 8'h80);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_no_result_cmd();
      t_result_only();
      t_exec_cmd();
      t_unknown();
      t_long_cmd();
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule